// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block keeps the interrupt presentation state of a single processor and drives its one interrupt line. It holds a 32-bit pending word, a pending-priority byte and an inter-processor-interrupt (IPI) priority byte. The pending word has the processor's current priority in bits 31:24 and the pending source number in bits 23:0. A source number of zero means that nothing is pending. A lower priority value is more favoured, and all ones means "none".

Interrupt sources offer requests, each made of a source number, a priority and an owner tag. The block accepts or rejects each request in the cycle it is offered. An accepted request may displace an interrupt that is already pending, and the displaced interrupt is then handed back to its owner on a notification port. That port also carries end-of-interrupt and resend messages. The processor side issues five operations: accept, poll, set current priority, set IPI priority and end-of-interrupt. The IPI competes with the sources as a pseudo-source that has its own fixed number.

Top module: `intr_present_ctrl`

## Requirements
- R1: After reset the pending word is 0, the pending priority and the IPI priority are all ones, `irq_out` is low, no notification is valid and `op_ready` is high.
- R2: An offered request is rejected (`req_nak`, no change of state) when its source number is zero or its priority is greater than or equal to the current priority.
- R3: An offered request is rejected when something is pending whose pending priority is less than or equal to the request priority.
- R4: A request that is not rejected is acknowledged (`req_ack`). It latches its source number, priority and owner, and `irq_out` is high from the next cycle. If a source interrupt was pending, the next cycle carries a REJECT notification (`nt_kind`=0) with the displaced source number and owner. `irq_out` is high exactly when the pending source number is nonzero.
- R5: ACCEPT (`op_code`=0) returns the old pending word on `rd_word` with `rd_valid` in the next cycle. The pending word becomes {pending priority, 0}, the pending priority becomes all ones and `irq_out` falls.
- R6: POLL (`op_code`=1) returns the pending word on `rd_word` and the IPI priority on `rd_ipi` in the next cycle, and changes no state.
- R7: SET_CUR (`op_code`=2, value in `op_data[7:0]`) with a more favoured value cancels a pending interrupt whose priority is not more favoured than the new value. The cancel clears the source, sets the pending priority to all ones, lowers `irq_out` and sends REJECT to the owner. An IPI has no owner, so no REJECT is sent for it.
- R8: SET_CUR with a value that is equal or less favoured, while nothing is pending, loads the IPI if the IPI priority is below the new current priority. It then emits a RESEND notification (`nt_kind`=2).
- R9: SET_IPI (`op_code`=3, value in `op_data[7:0]`) stores the IPI priority. If the value is below the current priority and nothing is pending at a priority less than or equal to it, the block rejects any pending source interrupt to its owner, loads source number 2, sets the pending priority to the value and raises `irq_out`.
- R10: EOI (`op_code`=4) sets the current priority from `op_data[31:24]` and emits an EOI notification (`nt_kind`=1) for `op_data[23:0]`. If nothing is pending, the IPI check of R8 runs, `op_ready` is low for one cycle and a RESEND notification follows one cycle after the EOI notification.
- R11: A request is answered only when `req_ready` is high. `req_ready` is low while `op_valid` is high or a resend is owed. A request offered while `req_ready` is low gets neither `req_ack` nor `req_nak`. At most one notification is valid per cycle.
- R12: `op_code` values 5 to 7 are ignored and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Source request offered |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Request priority |
| req_owner | input | 4 | Owner tag of the requesting source |
| req_ready | output | 1 | Request will be judged this cycle |
| req_ack | output | 1 | Request accepted |
| req_nak | output | 1 | Request rejected |
| op_valid | input | 1 | Processor operation valid |
| op_code | input | 3 | Operation code |
| op_data | input | 32 | Operation operand |
| op_ready | output | 1 | Operation taken this cycle |
| rd_valid | output | 1 | Read result valid |
| rd_word | output | 32 | Returned pending word |
| rd_ipi | output | 8 | Returned IPI priority |
| nt_valid | output | 1 | Notification strobe |
| nt_kind | output | 2 | 0 REJECT, 1 EOI, 2 RESEND |
| nt_src | output | 24 | Source number of the notification |
| nt_owner | output | 4 | Owner tag of a REJECT |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the block with its default parameters: a 24-bit source field, 8-bit priorities, 4-bit owner tags and IPI number 2. With these values the pending word is 32 bits wide. Priorities are drawn mostly from a small range, so that equal-priority ties, displacements and cancels happen often. Sources are drawn from a small set that includes number 2, so that IPI and source slots collide. The all-ones "none" priority is also reachable.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
   typedef enum logic [2:0] {
      OP_ACCEPT  = 3'd0,
      OP_POLL    = 3'd1,
      OP_SET_CUR = 3'd2,
      OP_SET_IPI = 3'd3,
      OP_EOI     = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      NT_REJECT = 2'd0,
      NT_EOI    = 2'd1,
      NT_RESEND = 2'd2,
      NT_NONE   = 2'd3
   } nt_e;
endpackage

// File: rtl/ipc_req_judge.sv
module ipc_req_judge #(
   parameter int SRC_W  = 24,
   parameter int PRIO_W = 8
) (
   input  logic [PRIO_W-1:0] cur_prio,
   input  logic [SRC_W-1:0]  pend_src,
   input  logic [PRIO_W-1:0] pend_prio,
   input  logic [SRC_W-1:0]  req_src,
   input  logic [PRIO_W-1:0] req_prio,
   output logic              take
);
   logic beaten_by_cur;
   logic beaten_by_pend;

   always_comb begin
      beaten_by_cur  = (req_prio >= cur_prio);
      beaten_by_pend = (pend_src != '0) && (pend_prio <= req_prio);
      take           = (req_src != '0) && !beaten_by_cur && !beaten_by_pend;
   end
endmodule

// File: rtl/ipc_ipi_check.sv
module ipc_ipi_check #(
   parameter int SRC_W  = 24,
   parameter int PRIO_W = 8
) (
   input  logic [PRIO_W-1:0] ipi_prio,
   input  logic [PRIO_W-1:0] cur_prio,
   input  logic [SRC_W-1:0]  pend_src,
   input  logic [PRIO_W-1:0] pend_prio,
   output logic              fire
);
   logic holds_better;

   always_comb begin
      holds_better = (pend_src != '0) && (pend_prio <= ipi_prio);
      fire         = (ipi_prio < cur_prio) && !holds_better;
   end
endmodule

// File: rtl/ipc_notify.sv
module ipc_notify
   import ipc_pkg::*;
#(
   parameter int SRC_W = 24,
   parameter int OWN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             send,
   input  nt_e              kind,
   input  logic [SRC_W-1:0] src,
   input  logic [OWN_W-1:0] owner,
   output logic             nt_valid,
   output logic [1:0]       nt_kind,
   output logic [SRC_W-1:0] nt_src,
   output logic [OWN_W-1:0] nt_owner
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nt_valid <= 1'b0;
         nt_kind  <= NT_NONE;
         nt_src   <= '0;
         nt_owner <= '0;
      end else begin
         nt_valid <= send;
         if (send) begin
            nt_kind  <= kind;
            nt_src   <= src;
            nt_owner <= owner;
         end
      end
   end
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl
   import ipc_pkg::*;
#(
   parameter int SRC_W   = 24,
   parameter int PRIO_W  = 8,
   parameter int OWN_W   = 4,
   parameter int IPI_SRC = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [SRC_W-1:0]         req_src,
   input  logic [PRIO_W-1:0]        req_prio,
   input  logic [OWN_W-1:0]         req_owner,
   output logic                     req_ready,
   output logic                     req_ack,
   output logic                     req_nak,
   input  logic                     op_valid,
   input  logic [2:0]               op_code,
   input  logic [PRIO_W+SRC_W-1:0]  op_data,
   output logic                     op_ready,
   output logic                     rd_valid,
   output logic [PRIO_W+SRC_W-1:0]  rd_word,
   output logic [PRIO_W-1:0]        rd_ipi,
   output logic                     nt_valid,
   output logic [1:0]               nt_kind,
   output logic [SRC_W-1:0]         nt_src,
   output logic [OWN_W-1:0]         nt_owner,
   output logic                     irq_out
);
   localparam int REG_W = PRIO_W + SRC_W;
   localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
   localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

   generate
      if (SRC_W < 2 || SRC_W > 30) begin : g_bad_src
         $error("SRC_W must lie in 2..30");
      end
      if (PRIO_W < 2 || OWN_W < 1) begin : g_bad_widths
         $error("PRIO_W must be at least 2 and OWN_W at least 1");
      end
      if (IPI_SRC < 1 || IPI_SRC >= (1 << SRC_W)) begin : g_bad_ipi
         $error("IPI_SRC must be a nonzero source number");
      end
   endgenerate

   // architectural state
   logic [PRIO_W-1:0] cur_q, cur_n;
   logic [SRC_W-1:0]  src_q, src_n;
   logic [PRIO_W-1:0] pp_q, pp_n;
   logic [PRIO_W-1:0] ipi_q, ipi_n;
   logic [OWN_W-1:0]  own_q, own_n;
   logic              ownv_q, ownv_n;
   logic              irq_q, irq_n;
   logic              busy_q, busy_n;
   logic              rdv_q, rdv_n;
   logic [REG_W-1:0]  rd_q, rd_n;
   logic [PRIO_W-1:0] rdi_q, rdi_n;

   // notification request
   logic              nt_send;
   nt_e               nt_k;
   logic [SRC_W-1:0]  nt_s;
   logic [OWN_W-1:0]  nt_o;

   logic op_go, req_go, take, ipi_fire;
   logic [PRIO_W-1:0] op_val, op_top, chk_ipi, chk_cur;

   assign op_go     = op_valid && !busy_q;
   assign op_ready  = !busy_q;
   assign req_ready = !op_valid && !busy_q;
   assign req_go    = req_valid && req_ready;
   assign op_val    = op_data[PRIO_W-1:0];
   assign op_top    = op_data[REG_W-1:SRC_W];

   ipc_req_judge #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_judge (
      .cur_prio (cur_q),
      .pend_src (src_q),
      .pend_prio(pp_q),
      .req_src  (req_src),
      .req_prio (req_prio),
      .take     (take)
   );

   assign req_ack = req_go && take;
   assign req_nak = req_go && !take;

   always_comb begin
      chk_ipi = (op_code == OP_SET_IPI) ? op_val : ipi_q;
      case (op_code)
         OP_SET_CUR: chk_cur = op_val;
         OP_EOI:     chk_cur = op_top;
         default:    chk_cur = cur_q;
      endcase
   end

   ipc_ipi_check #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipi (
      .ipi_prio (chk_ipi),
      .cur_prio (chk_cur),
      .pend_src (src_q),
      .pend_prio(pp_q),
      .fire     (ipi_fire)
   );

   always_comb begin
      cur_n   = cur_q;
      src_n   = src_q;
      pp_n    = pp_q;
      ipi_n   = ipi_q;
      own_n   = own_q;
      ownv_n  = ownv_q;
      irq_n   = irq_q;
      busy_n  = 1'b0;
      rdv_n   = 1'b0;
      rd_n    = rd_q;
      rdi_n   = rdi_q;
      nt_send = 1'b0;
      nt_k    = NT_NONE;
      nt_s    = '0;
      nt_o    = '0;
      if (busy_q) begin
         nt_send = 1'b1;
         nt_k    = NT_RESEND;
      end else if (op_valid) begin
         case (op_code)
            OP_ACCEPT: begin
               rdv_n  = 1'b1;
               rd_n   = {cur_q, src_q};
               rdi_n  = ipi_q;
               cur_n  = pp_q;
               src_n  = '0;
               pp_n   = PRIO_NONE;
               ownv_n = 1'b0;
               irq_n  = 1'b0;
            end
            OP_POLL: begin
               rdv_n = 1'b1;
               rd_n  = {cur_q, src_q};
               rdi_n = ipi_q;
            end
            OP_SET_CUR: begin
               cur_n = op_val;
               if (op_val < cur_q) begin
                  if (src_q != '0 && op_val <= pp_q) begin
                     src_n  = '0;
                     pp_n   = PRIO_NONE;
                     irq_n  = 1'b0;
                     ownv_n = 1'b0;
                     if (ownv_q) begin
                        nt_send = 1'b1;
                        nt_k    = NT_REJECT;
                        nt_s    = src_q;
                        nt_o    = own_q;
                     end
                  end
               end else if (src_q == '0) begin
                  if (ipi_fire) begin
                     src_n  = IPI_NUM;
                     pp_n   = ipi_q;
                     ownv_n = 1'b0;
                     irq_n  = 1'b1;
                  end
                  nt_send = 1'b1;
                  nt_k    = NT_RESEND;
               end
            end
            OP_SET_IPI: begin
               ipi_n = op_val;
               if (ipi_fire) begin
                  if (src_q != '0 && ownv_q) begin
                     nt_send = 1'b1;
                     nt_k    = NT_REJECT;
                     nt_s    = src_q;
                     nt_o    = own_q;
                  end
                  src_n  = IPI_NUM;
                  pp_n   = op_val;
                  ownv_n = 1'b0;
                  irq_n  = 1'b1;
               end
            end
            OP_EOI: begin
               cur_n   = op_top;
               nt_send = 1'b1;
               nt_k    = NT_EOI;
               nt_s    = op_data[SRC_W-1:0];
               if (src_q == '0) begin
                  busy_n = 1'b1;
                  if (ipi_fire) begin
                     src_n  = IPI_NUM;
                     pp_n   = ipi_q;
                     ownv_n = 1'b0;
                     irq_n  = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end else if (req_go && take) begin
         if (src_q != '0 && ownv_q) begin
            nt_send = 1'b1;
            nt_k    = NT_REJECT;
            nt_s    = src_q;
            nt_o    = own_q;
         end
         src_n  = req_src;
         pp_n   = req_prio;
         own_n  = req_owner;
         ownv_n = 1'b1;
         irq_n  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         src_q  <= '0;
         pp_q   <= PRIO_NONE;
         ipi_q  <= PRIO_NONE;
         own_q  <= '0;
         ownv_q <= 1'b0;
         irq_q  <= 1'b0;
         busy_q <= 1'b0;
         rdv_q  <= 1'b0;
         rd_q   <= '0;
         rdi_q  <= '0;
      end else begin
         cur_q  <= cur_n;
         src_q  <= src_n;
         pp_q   <= pp_n;
         ipi_q  <= ipi_n;
         own_q  <= own_n;
         ownv_q <= ownv_n;
         irq_q  <= irq_n;
         busy_q <= busy_n;
         rdv_q  <= rdv_n;
         rd_q   <= rd_n;
         rdi_q  <= rdi_n;
      end
   end

   assign irq_out  = irq_q;
   assign rd_valid = rdv_q;
   assign rd_word  = rd_q;
   assign rd_ipi   = rdi_q;

   ipc_notify #(.SRC_W(SRC_W), .OWN_W(OWN_W)) u_notify (
      .clk     (clk),
      .rst_n   (rst_n),
      .send    (nt_send),
      .kind    (nt_k),
      .src     (nt_s),
      .owner   (nt_o),
      .nt_valid(nt_valid),
      .nt_kind (nt_kind),
      .nt_src  (nt_src),
      .nt_owner(nt_owner)
   );

   // R4: line follows the pending source field
   a_r4_irq_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (src_q != '0));
   // R2/R3: a rejected request leaves the state alone
   a_r2_nak_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      req_nak |=> $stable(src_q) && $stable(pp_q) && $stable(cur_q) && $stable(irq_out));
   // R5: accept empties the pending slot
   a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (op_go && op_code == OP_ACCEPT) |=> (src_q == '0) && (pp_q == PRIO_NONE) && !irq_out && rd_valid);
   // R6: poll has no side effect
   a_r6_poll_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      (op_go && op_code == OP_POLL) |=> $stable(src_q) && $stable(pp_q) && $stable(cur_q) && $stable(ipi_q));
   // R9: a firing IPI check loads the IPI number
   a_r9_ipi_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (op_go && op_code == OP_SET_IPI && ipi_fire) |=> (src_q == IPI_NUM) && irq_out);
   // R10: an owed resend goes out next cycle
   a_r10_resend_follows: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> nt_valid && (nt_kind == NT_RESEND));
   // R11: exactly one answer when judged, none otherwise
   a_r11_single_answer: assert property (@(posedge clk) disable iff (!rst_n)
      req_go |-> ($countones({req_ack, req_nak}) == 1));
   a_r11_no_answer_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_go |-> !req_ack && !req_nak);
endmodule

// File: tb/test_intr_present_ctrl.sv
module test_intr_present_ctrl;
   localparam int SW = 24;
   localparam int PW = 8;
   localparam int OW = 4;
   localparam int RW = 32;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic          req_valid;
   logic [SW-1:0] req_src;
   logic [PW-1:0] req_prio;
   logic [OW-1:0] req_owner;
   logic          req_ready, req_ack, req_nak;
   logic          op_valid;
   logic [2:0]    op_code;
   logic [RW-1:0] op_data;
   logic          op_ready, rd_valid;
   logic [RW-1:0] rd_word;
   logic [PW-1:0] rd_ipi;
   logic          nt_valid;
   logic [1:0]    nt_kind;
   logic [SW-1:0] nt_src;
   logic [OW-1:0] nt_owner;
   logic          irq_out;

   intr_present_ctrl i_intr_present_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio), .req_owner(req_owner),
      .req_ready(req_ready), .req_ack(req_ack), .req_nak(req_nak),
      .op_valid(op_valid), .op_code(op_code), .op_data(op_data), .op_ready(op_ready),
      .rd_valid(rd_valid), .rd_word(rd_word), .rd_ipi(rd_ipi),
      .nt_valid(nt_valid), .nt_kind(nt_kind), .nt_src(nt_src), .nt_owner(nt_owner),
      .irq_out(irq_out)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // reference state
   logic [PW-1:0] m_cur, m_pp, m_ipi;
   logic [SW-1:0] m_src;
   logic [OW-1:0] m_own;
   bit            m_ownv, m_busy;
   // expectations for the current step
   bit            e_ntv, e_rdv;
   logic [1:0]    e_kind;
   logic [SW-1:0] e_src;
   logic [OW-1:0] e_own;
   logic [RW-1:0] e_rd;
   logic [PW-1:0] e_ipi;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit ipi_wins(input logic [PW-1:0] ipi, input logic [PW-1:0] cur);
      return (ipi < cur) && !(m_src != 0 && m_pp <= ipi);
   endfunction

   task automatic note(input logic [1:0] k, input logic [SW-1:0] s, input logic [OW-1:0] o);
      e_ntv = 1; e_kind = k; e_src = s; e_own = o;
   endtask

   task automatic load_ipi(input logic [PW-1:0] p);
      m_src = SW'(2); m_pp = p; m_ownv = 0;
   endtask

   task automatic clear_exp;
      e_ntv = 0; e_rdv = 0; e_kind = 0; e_src = 0; e_own = 0; e_rd = 0; e_ipi = 0;
   endtask

   task automatic finish_step(input string tag);
      @(negedge clk);
      req_valid = 0; op_valid = 0;
      chk(nt_valid == e_ntv, {tag, " R11 notify strobe"}, 32'(nt_valid), 32'(e_ntv));
      if (e_ntv) begin
         chk(nt_kind == e_kind, {tag, " notify kind"}, 32'(nt_kind), 32'(e_kind));
         chk(nt_src == e_src, {tag, " notify source"}, 32'(nt_src), 32'(e_src));
         if (e_kind == 2'd0)
            chk(nt_owner == e_own, {tag, " notify owner"}, 32'(nt_owner), 32'(e_own));
      end
      chk(irq_out == (m_src != 0), {tag, " R4 irq line"}, 32'(irq_out), 32'(m_src != 0));
      chk(rd_valid == e_rdv, {tag, " R5/R6 read strobe"}, 32'(rd_valid), 32'(e_rdv));
      if (e_rdv) begin
         chk(rd_word == e_rd, {tag, " read word"}, rd_word, e_rd);
         chk(rd_ipi == e_ipi, {tag, " read ipi"}, 32'(rd_ipi), 32'(e_ipi));
      end
      if (m_busy) begin
         chk(op_ready == 0 && req_ready == 0, "R10 ready low while resend owed", 32'(op_ready), 0);
         @(negedge clk);
         chk(nt_valid == 1 && nt_kind == 2'd2, "R10 deferred RESEND", 32'(nt_kind), 2);
         m_busy = 0;
      end
   endtask

   task automatic do_req(input logic [SW-1:0] s, input logic [PW-1:0] p, input logic [OW-1:0] o);
      bit take;
      clear_exp();
      take = (s != 0) && (p < m_cur) && !(m_src != 0 && m_pp <= p);
      @(negedge clk);
      req_valid = 1; req_src = s; req_prio = p; req_owner = o;
      #1;
      chk(req_ready == 1, "R11 ready when idle", 32'(req_ready), 1);
      chk(req_ack == take && req_nak == !take, take ? "R4 request accepted" : "R2/R3 request rejected",
          32'({req_ack, req_nak}), 32'({take, !take}));
      if (take) begin
         if (m_src != 0 && m_ownv) note(2'd0, m_src, m_own);
         m_src = s; m_pp = p; m_own = o; m_ownv = 1;
      end
      finish_step("request");
   endtask

   task automatic do_op(input logic [2:0] code, input logic [RW-1:0] d, input bit with_req);
      logic [PW-1:0] v;
      clear_exp();
      v = d[PW-1:0];
      case (code)
         3'd0: begin
            e_rdv = 1; e_rd = {m_cur, m_src}; e_ipi = m_ipi;
            m_cur = m_pp; m_src = 0; m_pp = 8'hFF; m_ownv = 0;
         end
         3'd1: begin
            e_rdv = 1; e_rd = {m_cur, m_src}; e_ipi = m_ipi;
         end
         3'd2: begin
            if (v < m_cur) begin
               if (m_src != 0 && v <= m_pp) begin
                  if (m_ownv) note(2'd0, m_src, m_own);
                  m_src = 0; m_pp = 8'hFF; m_ownv = 0;
               end
               m_cur = v;
            end else begin
               m_cur = v;
               if (m_src == 0) begin
                  if (m_ipi < m_cur) load_ipi(m_ipi);
                  note(2'd2, 0, 0);
               end
            end
         end
         3'd3: begin
            if (ipi_wins(v, m_cur)) begin
               if (m_src != 0 && m_ownv) note(2'd0, m_src, m_own);
               load_ipi(v);
            end
            m_ipi = v;
         end
         3'd4: begin
            m_cur = d[31:24];
            note(2'd1, d[23:0], 0);
            if (m_src == 0) begin
               if (m_ipi < m_cur) load_ipi(m_ipi);
               m_busy = 1;
            end
         end
         default: ;
      endcase
      @(negedge clk);
      op_valid = 1; op_code = code; op_data = d;
      if (with_req) begin
         req_valid = 1; req_src = 24'd9; req_prio = 8'd0; req_owner = 4'd5;
      end
      #1;
      chk(op_ready == 1, "R11 op ready", 32'(op_ready), 1);
      if (with_req)
         chk(!req_ready && !req_ack && !req_nak, "R11 request held off during op",
             32'({req_ready, req_ack, req_nak}), 0);
      finish_step("op");
   endtask

   task automatic poll_check(input string tag);
      do_op(3'd1, 0, 0);
      chk(1'b1, tag, 0, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1c5a);
      rst_n = 0; req_valid = 0; op_valid = 0;
      req_src = 0; req_prio = 0; req_owner = 0; op_code = 0; op_data = 0;
      m_cur = 0; m_src = 0; m_pp = 8'hFF; m_ipi = 8'hFF; m_own = 0; m_ownv = 0; m_busy = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(irq_out == 0, "R1 irq low after reset", 32'(irq_out), 0);
      chk(nt_valid == 0, "R1 no notification after reset", 32'(nt_valid), 0);
      chk(op_ready == 1, "R1 op_ready after reset", 32'(op_ready), 1);
      do_op(3'd1, 0, 0);                  // R1: poll shows word 0 and ipi FF
      do_req(24'd4, 8'd1, 4'd2);          // R2: cur 0 rejects anything
      do_op(3'd2, 32'hFF, 0);             // R8: resend, no IPI load
      do_req(24'd0, 8'd1, 4'd2);          // R2: source zero rejected
      do_req(24'd5, 8'd10, 4'd3);         // R4 accept
      do_req(24'd6, 8'd10, 4'd4);         // R3 tie rejected
      do_req(24'd7, 8'd4, 4'd1);          // R4 displacement reject of 5
      do_op(3'd2, 32'h05, 0);             // R7 no cancel (pending 4 is better)
      do_op(3'd2, 32'h04, 0);             // R7 cancel, reject 7 to owner 1
      do_req(24'd8, 8'd4, 4'd6);          // R2 prio equal to current
      do_op(3'd3, 32'h02, 0);             // R9 load IPI
      do_op(3'd1, 0, 0);                  // R6 poll {04,000002}
      do_op(3'd3, 32'h03, 0);             // R9 IPI held: pending 2 beats 3
      do_op(3'd6, 32'h00, 0);             // R12 ignored code
      do_op(3'd1, 0, 0);                  // R12 state unchanged
      do_op(3'd0, 0, 1);                  // R5 accept, R11 request held off
      do_op(3'd4, 32'hFF000002, 0);       // R10 EOI then deferred resend, IPI reload
      do_op(3'd0, 0, 0);                  // R5
      do_op(3'd3, 32'hFF, 0);             // R9 IPI off
      do_op(3'd4, 32'hFF000002, 0);       // R10 EOI, resend, nothing loaded
      do_req(24'd2, 8'd9, 4'd7);          // R4 source reusing IPI number
      do_op(3'd2, 32'h09, 0);             // R7 cancel with reject to owner 7
      // random phase
      for (int i = 0; i < 400; i++) begin
         int unsigned r;
         logic [PW-1:0] p;
         r = $urandom % 100;
         p = ($urandom % 10 == 0) ? 8'hFF : PW'($urandom % 16);
         if (r < 40)
            do_req(SW'($urandom % 12), p, OW'($urandom));
         else if (r < 50)
            do_op(3'd0, 0, ($urandom % 4) == 0);
         else if (r < 60)
            do_op(3'd1, 0, 0);
         else if (r < 75)
            do_op(3'd2, RW'(p), 0);
         else if (r < 85)
            do_op(3'd3, RW'(p), 0);
         else if (r < 97)
            do_op(3'd4, {p, SW'($urandom % 12)}, 0);
         else
            do_op(3'($urandom % 3 + 5), $urandom, 0);
      end
      do_op(3'd1, 0, 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule